// File: doc/BRIEF.md
# Connection Memory Block Initializer

This unit loads one control pattern into every word of a 16-bit connection memory with no help from software. Software first raises an arming bit and then sets a start bit. The unit keeps that start bit as its own flag, `en_o`. At the next frame pulse it walks the memory one word per clock. Each word gets the 5-bit pattern in its top bits and zeros in all lower bits. When the last word has been written, the unit drops its flag by itself.

The number of words follows the data-rate setting: 16 streams times 32, 64 or 128 channels. The whole fill therefore fits inside two frames. Ordinary connection-memory traffic during a fill is handled outside this unit.

Top module: `cmb_block_init`

## Requirements
- R1: After reset, `en_o`, `busy_o` and `wr_en_o` are low.
- R2: When `en_set_i` and `arm_i` are both high at a clock edge, `en_o` is high from the next cycle. When `en_set_i` is high while `arm_i` is low, nothing happens: `en_o` stays low and no write follows.
- R3: With `en_o` high, the first clock edge that samples `frame_i` high starts the fill. `busy_o` and `wr_en_o` go high in the following cycle.
- R4: During a fill there is exactly one write per cycle. The addresses run 0, 1, 2, … up to depth−1 in consecutive cycles with no gaps.
- R5: Every written word carries the pattern in bits 15 down to 11, with pattern bit 0 in word bit 11. Bits 10 down to 0 are zero.
- R6: The pattern is sampled at the start edge. Changes on `pattern_i` during the fill do not alter the written words.
- R7: The depth is 512 words for `rate_i`=0, 1024 for 1 and 2048 for 2. Code 3 is treated as 2048.
- R8: In the cycle after the last write, `en_o`, `busy_o` and `wr_en_o` are all low. The fill ends no later than the second frame pulse after the flag was set.
- R9: A pulse on `en_set_i` while `en_o` is already high, whether waiting or filling, is ignored. It does not restart the fill, and the total write count stays at the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | Frame start pulse, one cycle wide |
| arm_i | input | 1 | Block-mode arming bit |
| en_set_i | input | 1 | Pulse that sets the start flag |
| pattern_i | input | 5 | Fill pattern for the top bits |
| rate_i | input | 2 | Data-rate code selecting the depth |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 11 | Memory write address |
| wr_data_o | output | 16 | Memory write data |
| busy_o | output | 1 | High while words are being written |
| en_o | output | 1 | Start flag, cleared by the unit when the fill ends |

## Verification
The bench builds the unit with its default parameters: 16 streams, a base of 32 channels and three rate steps. Every depth from 512 to 2048 words can therefore be reached, as can the clamped rate code 3. Its frame pulse is spaced one full depth apart. This makes the fill use exactly one frame and places its last write right against the next pulse, which is the tightest case for the two-frame bound.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
   typedef enum logic [1:0] {
      CMB_IDLE = 2'd0,
      CMB_WAIT = 2'd1,
      CMB_FILL = 2'd2
   } cmb_state_e;

   // words to fill for a rate code; codes past the last step clamp
   function automatic int unsigned cmb_depth(input int unsigned streams,
                                             input int unsigned base_ch,
                                             input int unsigned n_rates,
                                             input int unsigned code);
      int unsigned c;
      c = (code >= n_rates) ? n_rates - 1 : code;
      return (streams * base_ch) << c;
   endfunction
endpackage

// File: rtl/cmb_fill_ctrl.sv
module cmb_fill_ctrl
   import cmb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_i,
   input  logic arm_i,
   input  logic en_set_i,
   input  logic last_i,
   output logic start_o,
   output logic run_o,
   output logic en_o
);
   cmb_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CMB_IDLE: if (en_set_i && arm_i) state_d = CMB_WAIT;
         CMB_WAIT: if (frame_i)           state_d = CMB_FILL;
         CMB_FILL: if (last_i)            state_d = CMB_IDLE;
         default:                         state_d = CMB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= CMB_IDLE;
      else        state_q <= state_d;
   end

   assign start_o = (state_q == CMB_WAIT) && frame_i;
   assign run_o   = (state_q == CMB_FILL);
   assign en_o    = (state_q != CMB_IDLE);
endmodule

// File: rtl/cmb_addr_gen.sv
module cmb_addr_gen
   import cmb_pkg::*;
#(
   parameter int unsigned STREAMS  = 16,
   parameter int unsigned BASE_CH  = 32,
   parameter int unsigned NUM_RATES = 3,
   parameter int unsigned RATE_W   = 2,
   parameter int unsigned ADDR_W   = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              run_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   logic [ADDR_W-1:0] cnt_q, lim_q;
   int unsigned       depth;

   always_comb depth = cmb_depth(STREAMS, BASE_CH, NUM_RATES, int'(rate_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (start_i) begin
         cnt_q <= '0;
         lim_q <= ADDR_W'(depth - 1);
      end else if (run_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign addr_o = cnt_q;
   assign last_o = run_i && (cnt_q == lim_q);
endmodule

// File: rtl/cmb_word_fmt.sv
module cmb_word_fmt #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned PAT_W   = 5,
   parameter int unsigned PAT_LSB = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [PAT_W-1:0]  pattern_i,
   output logic [DATA_W-1:0] word_o
);
   logic [PAT_W-1:0] pat_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      pat_q <= '0;
      else if (load_i) pat_q <= pattern_i;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i >= PAT_LSB && i < PAT_LSB + PAT_W) begin : g_pat
         assign word_o[i] = pat_q[i-PAT_LSB];
      end else begin : g_zero
         assign word_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/cmb_block_init.sv
module cmb_block_init
   import cmb_pkg::*;
#(
   parameter int unsigned STREAMS   = 16,
   parameter int unsigned BASE_CH   = 32,
   parameter int unsigned NUM_RATES = 3,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned PAT_W     = 5,
   parameter int unsigned PAT_LSB   = 11,
   parameter int unsigned RATE_W    = 2,
   localparam int unsigned MAX_DEPTH = (STREAMS * BASE_CH) << (NUM_RATES - 1),
   localparam int unsigned ADDR_W    = $clog2(MAX_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_i,
   input  logic              arm_i,
   input  logic              en_set_i,
   input  logic [PAT_W-1:0]  pattern_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              en_o
);
   if (PAT_LSB + PAT_W > DATA_W) begin : g_bad_field
      $error("pattern field does not fit in the word");
   end
   if (NUM_RATES == 0 || (1 << RATE_W) < NUM_RATES) begin : g_bad_rate
      $error("rate code too narrow for the rate steps");
   end

   logic start, run, last;

   cmb_fill_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_i  (frame_i),
      .arm_i    (arm_i),
      .en_set_i (en_set_i),
      .last_i   (last),
      .start_o  (start),
      .run_o    (run),
      .en_o     (en_o)
   );

   cmb_addr_gen #(
      .STREAMS   (STREAMS),
      .BASE_CH   (BASE_CH),
      .NUM_RATES (NUM_RATES),
      .RATE_W    (RATE_W),
      .ADDR_W    (ADDR_W)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .run_i   (run),
      .rate_i  (rate_i),
      .addr_o  (wr_addr_o),
      .last_o  (last)
   );

   cmb_word_fmt #(
      .DATA_W  (DATA_W),
      .PAT_W   (PAT_W),
      .PAT_LSB (PAT_LSB)
   ) u_fmt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (start),
      .pattern_i (pattern_i),
      .word_o    (wr_data_o)
   );

   assign wr_en_o = run;
   assign busy_o  = run;
endmodule

// File: rtl/cmb_block_init_chk.sv
module cmb_block_init_chk #(
   parameter int unsigned ADDR_W  = 11,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned PAT_LSB = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_i,
   input logic              arm_i,
   input logic              en_set_i,
   input logic              wr_en_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic              busy_o,
   input logic              en_o
);
   p_set_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o) |-> $past(arm_i && en_set_i));

   p_start_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(frame_i && en_o));

   p_first_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en_o) |-> (wr_addr_o == '0));

   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + 1'b1));

   p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_data_o[PAT_LSB-1:0] == '0));

   p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(wr_en_o)) |-> $stable(wr_data_o));

   p_write_under_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> en_o);

   p_clear_after_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_o) |-> $past(wr_en_o));
endmodule

bind cmb_block_init cmb_block_init_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .PAT_LSB (PAT_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_i   (frame_i),
   .arm_i     (arm_i),
   .en_set_i  (en_set_i),
   .wr_en_o   (wr_en_o),
   .wr_addr_o (wr_addr_o),
   .wr_data_o (wr_data_o),
   .busy_o    (busy_o),
   .en_o      (en_o)
);

// File: tb/cmb_block_init_tb.sv
module cmb_block_init_tb;
   localparam int CLK_NS = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_i = 1'b0;
   logic        arm_i = 1'b0;
   logic        en_set_i = 1'b0;
   logic [4:0]  pattern_i = '0;
   logic [1:0]  rate_i = '0;
   logic        wr_en_o, busy_o, en_o;
   logic [10:0] wr_addr_o;
   logic [15:0] wr_data_o;

   int tests = 0;
   int fails = 0;
   int fper = 512;
   int fcnt = 0;

   always #(CLK_NS/2) clk = ~clk;

   cmb_block_init u_dut (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .arm_i(arm_i),
      .en_set_i(en_set_i), .pattern_i(pattern_i), .rate_i(rate_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .busy_o(busy_o), .en_o(en_o)
   );

   function automatic int exp_depth(input int code);
      return 512 << ((code > 2) ? 2 : code);
   endfunction

   function automatic logic [15:0] exp_word(input logic [4:0] p);
      return {p, 11'd0};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // frame pulse generator, one pulse every fper cycles
   initial begin
      forever begin
         @(negedge clk);
         frame_i = (fcnt == 0);
         fcnt = (fcnt >= fper - 1) ? 0 : fcnt + 1;
      end
   end

   task automatic run_fill(input logic [4:0] pat, input int code, input bit poke);
      int n = 0;
      int frames = 0;
      bit prev_frame = 0;
      @(negedge clk);
      fper = exp_depth(code);
      pattern_i = pat;
      rate_i = 2'(code);
      arm_i = 1'b1;
      en_set_i = 1'b1;
      @(negedge clk);
      en_set_i = 1'b0;
      chk(en_o === 1'b1, "R2 flag set", int'(en_o), 1);
      while (!busy_o) begin
         if (frame_i) frames++;
         prev_frame = frame_i;
         @(negedge clk);
         if (poke && !busy_o) en_set_i = 1'b1;
      end
      en_set_i = 1'b0;
      chk(prev_frame, "R3 start follows frame", int'(prev_frame), 1);
      while (wr_en_o) begin
         if (frame_i) frames++;
         chk(wr_addr_o == 11'(n), "R4 address", int'(wr_addr_o), n);
         chk(wr_data_o == exp_word(pat), "R5 word", int'(wr_data_o), int'(exp_word(pat)));
         n++;
         if (n == 3) begin
            pattern_i = ~pat;          // R6: must not show up
            if (poke) en_set_i = 1'b1; // R9: must not restart
         end else begin
            en_set_i = 1'b0;
         end
         @(negedge clk);
      end
      en_set_i = 1'b0;
      chk(n == exp_depth(code), "R7 depth", n, exp_depth(code));
      chk(en_o == 1'b0 && busy_o == 1'b0, "R8 self clear", int'({en_o, busy_o}), 0);
      chk(frames <= 2, "R8 two frames", frames, 2);
      repeat (4) @(negedge clk);
      chk(!wr_en_o && !en_o, "R9 no restart", int'({wr_en_o, en_o}), 0);
   endtask

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      chk(!en_o && !busy_o && !wr_en_o, "R1 reset state", int'({en_o, busy_o, wr_en_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!en_o && !busy_o && !wr_en_o, "R1 after release", int'({en_o, busy_o, wr_en_o}), 0);

      // R2: start without arming is ignored
      arm_i = 1'b0;
      en_set_i = 1'b1;
      @(negedge clk);
      en_set_i = 1'b0;
      begin
         bit seen = 0;
         for (int i = 0; i < 600; i++) begin
            if (en_o || wr_en_o) seen = 1;
            @(negedge clk);
         end
         chk(!seen, "R2 unarmed ignored", int'(seen), 0);
      end

      run_fill(5'b10110, 0, 1'b0);
      run_fill(5'b11111, 3, 1'b1);   // R7 clamp, R9 pokes
      run_fill(5'b00001, 1, 1'b1);
      for (int k = 0; k < 4; k++) begin
         run_fill(5'($urandom), int'($urandom_range(0, 3)), 1'($urandom));
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_NS * 200000);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule